// File: doc/BRIEF.md
# Flash Programming Controller Register Front End

This block is the bus-facing side of an on-chip flash programming engine. A 32-bit peripheral bus reaches four word registers inside a 1 KiB window: a RAM source word address, a flash destination word address (also the page pointer for an erase), a command select register and a self-clearing execute bit. Both addresses are word addresses, so software drops the two always-zero byte bits before writing them.

Writing 1 to the execute bit starts the selected command. A page erase raises one request on the flash port. A multi-word program runs a loop: it fetches a word from RAM, hands it to the flash port, then advances both addresses. The RAM address register itself counts forward. The flash destination is advanced in a private counter, so the flash address register keeps its value. The RAM and the flash array sit outside the block, each behind a request/acknowledge port.

While a command runs, a bus write is stalled by holding ready low. It commits in the first cycle the engine is idle. Reads always complete in the cycle they are presented.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset every register reads 0, busy is low and neither ram_req nor fl_req is asserted.
- R2: The RAM address register (word offset 0, byte offset 0x000) keeps write data bits 10:0; bits 31:11 read as 0.
- R3: The flash address register (byte offset 0x004) keeps write data bits 14:0, bits 31:15 read as 0, and a program operation leaves its value unchanged.
- R4: The command register (byte offset 0x008) keeps bits 2:0 as the command (0 no-op, 1 page erase, 2 program, other values no-op) and bits 15:8 as word count minus one; all other bits read as 0.
- R5: The execute register (byte offset 0x00C) always reads 0; a committed write with bit 0 set starts the command held in the command register, and a write with bit 0 clear, or a start of a no-op, leaves busy low.
- R6: A page erase holds fl_req with fl_erase high and fl_addr equal to the flash address register until fl_ack, then the engine goes idle.
- R7: A program of N words repeats N times: ram_req with ram_addr until ram_ack, then fl_req with fl_erase low, fl_wdata equal to the fetched word and fl_addr equal to the flash address register plus the word index (15-bit wrap), held until fl_ack.
- R8: Each fl_ack during a program adds 1 to the RAM address register (11-bit wrap), so after N words it reads start plus N.
- R9: A read is completed with bus_ready high in the same cycle it is presented, busy or not, and returns the current register value.
- R10: A write presented while busy is high sees bus_ready low and is not applied; it commits in the first cycle busy is low, with bus_ready high in that cycle.
- R11: A completed access to a byte offset of 0x010 or above reads 0, changes no register and asserts bus_err for that one cycle only.
- R12: busy rises in the cycle after the committing execute write of an erase or program and falls in the cycle after the final fl_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 10 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Access completes this cycle |
| bus_err | output | 1 | Access to an unused offset |
| busy | output | 1 | Command in progress |
| ram_req | output | 1 | RAM word fetch request |
| ram_addr | output | 11 | RAM word address |
| ram_ack | input | 1 | RAM data valid |
| ram_rdata | input | 32 | RAM word |
| fl_req | output | 1 | Flash operation request |
| fl_erase | output | 1 | 1 page erase, 0 word program |
| fl_addr | output | 15 | Flash word or page address |
| fl_wdata | output | 32 | Word to program |
| fl_ack | input | 1 | Flash operation done |

## Verification
Two functions can meet in one cycle: a bus read of the RAM address register and the engine's increment of that register on a final fl_ack, and a stalled write committing in the cycle the engine drops busy. The bench polls the RAM address every cycle of a program that starts near the top of the 11-bit range and wraps, and issues flash address and execute writes while busy so they are held back and then commit. A behavioural model with its own counters predicts rdata, ready, err and every port of the engine on each clock, and the final register contents are read back and compared.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  // Word index of each register inside the window (byte offset >> 2)
  localparam int IDX_RAM = 0;
  localparam int IDX_FL  = 1;
  localparam int IDX_CMD = 2;
  localparam int IDX_EXE = 3;
  localparam int NUM_REGS = 4;

  // Command field position and codes
  localparam int CNT_LSB = 8;
  localparam logic [2:0] CMD_ERASE = 3'd1;
  localparam logic [2:0] CMD_PROG  = 3'd2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_WRITE = 2'd2,
    SQ_ERASE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/flash_regfile.sv
module flash_regfile
  import flash_ctl_pkg::*;
#(
  parameter int DW     = 32,
  parameter int OFS_W  = 10,
  parameter int RAM_AW = 11,
  parameter int FL_AW  = 15,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [OFS_W-1:0]  addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              ready,
  output logic              err,
  input  logic              busy,
  input  logic              ram_inc,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [FL_AW-1:0]  fl_waddr,
  output logic [2:0]        cmd_sel,
  output logic [CNT_W-1:0]  cmd_cnt,
  output logic              exec_go
);
  localparam int IDX_W = OFS_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              hit_ram, hit_fl, hit_cmd, hit_exe, mapped, commit;
  logic [RAM_AW-1:0] ram_q, ram_d;
  logic [FL_AW-1:0]  fl_q;
  logic [2:0]        cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ram_en, fl_en, cmd_en;
  logic              unused_bits;

  assign idx     = addr[OFS_W-1:2];
  assign hit_ram = (idx == IDX_W'(IDX_RAM));
  assign hit_fl  = (idx == IDX_W'(IDX_FL));
  assign hit_cmd = (idx == IDX_W'(IDX_CMD));
  assign hit_exe = (idx == IDX_W'(IDX_EXE));
  assign mapped  = hit_ram | hit_fl | hit_cmd | hit_exe;

  // Writes stall while the engine runs; reads never do
  assign ready   = ~(req & we & busy);
  assign commit  = req & we & ready;
  assign err     = req & ready & ~mapped;
  assign exec_go = commit & hit_exe & wdata[0];

  // Clock enables
  assign ram_en = (commit & hit_ram) | ram_inc;
  assign fl_en  = commit & hit_fl;
  assign cmd_en = commit & hit_cmd;

  always_comb begin
    ram_d = ram_q;
    if (commit && hit_ram) ram_d = wdata[RAM_AW-1:0];
    else if (ram_inc)      ram_d = ram_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q <= '0;
      fl_q  <= '0;
      cmd_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ram_en) ram_q <= ram_d;
      if (fl_en)  fl_q  <= wdata[FL_AW-1:0];
      if (cmd_en) begin
        cmd_q <= wdata[2:0];
        cnt_q <= wdata[CNT_LSB +: CNT_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ram) rdata[RAM_AW-1:0] = ram_q;
    if (hit_fl)  rdata[FL_AW-1:0]  = fl_q;
    if (hit_cmd) begin
      rdata[2:0]              = cmd_q;
      rdata[CNT_LSB +: CNT_W] = cnt_q;
    end
  end

  assign ram_waddr = ram_q;
  assign fl_waddr  = fl_q;
  assign cmd_sel   = cmd_q;
  assign cmd_cnt   = cnt_q;

  assign unused_bits = ^{wdata[DW-1:CNT_LSB+CNT_W], addr[1:0]};
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_ctl_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FL_AW  = 15,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_go,
  input  logic [2:0]       cmd_sel,
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic [FL_AW-1:0] fl_waddr,
  input  logic             ram_ack,
  input  logic [DW-1:0]    ram_rdata,
  input  logic             fl_ack,
  output logic             busy,
  output logic             ram_req,
  output logic             ram_inc,
  output logic             fl_req,
  output logic             fl_erase,
  output logic [FL_AW-1:0] fl_addr,
  output logic [DW-1:0]    fl_wdata
);
  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [FL_AW-1:0] fcnt_q, fcnt_d;
  logic [DW-1:0]    buf_q;
  logic             buf_en;

  assign buf_en = (st_q == SQ_FETCH) & ram_ack;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    fcnt_d = fcnt_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (exec_go) begin
          if (cmd_sel == CMD_ERASE) begin
            st_d = SQ_ERASE;
          end else if (cmd_sel == CMD_PROG) begin
            st_d   = SQ_FETCH;
            rem_d  = cmd_cnt;
            fcnt_d = fl_waddr;
          end
        end
      end
      SQ_FETCH: if (ram_ack) st_d = SQ_WRITE;
      SQ_WRITE: begin
        if (fl_ack) begin
          fcnt_d = fcnt_q + 1'b1;
          if (rem_q == '0) begin
            st_d = SQ_IDLE;
          end else begin
            rem_d = rem_q - 1'b1;
            st_d  = SQ_FETCH;
          end
        end
      end
      SQ_ERASE: if (fl_ack) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      rem_q  <= '0;
      fcnt_q <= '0;
      buf_q  <= '0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      fcnt_q <= fcnt_d;
      if (buf_en) buf_q <= ram_rdata;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign ram_req  = (st_q == SQ_FETCH);
  assign ram_inc  = (st_q == SQ_WRITE) & fl_ack;
  assign fl_req   = (st_q == SQ_WRITE) | (st_q == SQ_ERASE);
  assign fl_erase = (st_q == SQ_ERASE);
  assign fl_addr  = (st_q == SQ_ERASE) ? fl_waddr : fcnt_q;
  assign fl_wdata = buf_q;
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import flash_ctl_pkg::*;
#(
  parameter int DW     = 32,
  parameter int OFS_W  = 10,
  parameter int RAM_AW = 11,
  parameter int FL_AW  = 15,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ready,
  output logic              bus_err,
  output logic              busy,
  output logic              ram_req,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic              ram_ack,
  input  logic [DW-1:0]     ram_rdata,
  output logic              fl_req,
  output logic              fl_erase,
  output logic [FL_AW-1:0]  fl_addr,
  output logic [DW-1:0]     fl_wdata,
  input  logic              fl_ack
);
  logic             ram_inc, exec_go;
  logic [FL_AW-1:0] fl_waddr;
  logic [2:0]       cmd_sel;
  logic [CNT_W-1:0] cmd_cnt;

  flash_regfile #(
    .DW(DW), .OFS_W(OFS_W), .RAM_AW(RAM_AW), .FL_AW(FL_AW), .CNT_W(CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (bus_req),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .ready     (bus_ready),
    .err       (bus_err),
    .busy      (busy),
    .ram_inc   (ram_inc),
    .ram_waddr (ram_addr),
    .fl_waddr  (fl_waddr),
    .cmd_sel   (cmd_sel),
    .cmd_cnt   (cmd_cnt),
    .exec_go   (exec_go)
  );

  flash_seq #(
    .DW(DW), .FL_AW(FL_AW), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_go   (exec_go),
    .cmd_sel   (cmd_sel),
    .cmd_cnt   (cmd_cnt),
    .fl_waddr  (fl_waddr),
    .ram_ack   (ram_ack),
    .ram_rdata (ram_rdata),
    .fl_ack    (fl_ack),
    .busy      (busy),
    .ram_req   (ram_req),
    .ram_inc   (ram_inc),
    .fl_req    (fl_req),
    .fl_erase  (fl_erase),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata)
  );
endmodule

// File: rtl/flash_ctl_chk.sv
module flash_ctl_chk #(
  parameter int DW     = 32,
  parameter int IDX_W  = 8,
  parameter int RAM_AW = 11,
  parameter int FL_AW  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [IDX_W-1:0]  word_idx,
  input logic [DW-1:0]     bus_rdata,
  input logic              bus_ready,
  input logic              bus_err,
  input logic              busy,
  input logic              ram_req,
  input logic              ram_ack,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              fl_req,
  input logic              fl_erase,
  input logic              fl_ack,
  input logic [FL_AW-1:0]  fl_addr
);
  logic rd;
  assign rd = bus_req & ~bus_we;

  AST_READ_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> bus_ready) else $error("read stalled"); // R9

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && busy) |-> !bus_ready) else $error("write not held"); // R10

  AST_EXEC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && word_idx == IDX_W'(3)) |-> bus_rdata == '0) else $error("exec read nonzero"); // R5

  AST_RAM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && word_idx == '0) |-> bus_rdata[DW-1:RAM_AW] == '0) else $error("ram upper bits"); // R2

  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !bus_we) |-> bus_rdata == '0) else $error("err read nonzero"); // R11

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_req && fl_req)) else $error("both ports requested"); // R7

  AST_RAM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && !ram_ack) |=> (ram_req && $stable(ram_addr))) else $error("ram req dropped"); // R7

  AST_FL_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_erase))) else $error("flash req dropped"); // R6

  AST_RAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && $past(fl_req)) |-> ram_addr == RAM_AW'($past(ram_addr) + 1'b1)) else $error("ram step"); // R8

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req || fl_req) |-> busy) else $error("request while idle"); // R12
endmodule

bind flash_ctl_regs flash_ctl_chk #(
  .DW(DW), .IDX_W(OFS_W-2), .RAM_AW(RAM_AW), .FL_AW(FL_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .word_idx  (bus_addr[OFS_W-1:2]),
  .bus_rdata (bus_rdata),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .busy      (busy),
  .ram_req   (ram_req),
  .ram_ack   (ram_ack),
  .ram_addr  (ram_addr),
  .fl_req    (fl_req),
  .fl_erase  (fl_erase),
  .fl_ack    (fl_ack),
  .fl_addr   (fl_addr)
);

// File: tb/tb_flash_ctl_regs.sv
module tb_flash_ctl_regs;
  localparam int P = 10;

  logic        clk, rst_n;
  logic        bus_req, bus_we;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready, bus_err, busy;
  logic        ram_req, ram_ack;
  logic [10:0] ram_addr;
  logic [31:0] ram_rdata;
  logic        fl_req, fl_erase, fl_ack;
  logic [14:0] fl_addr;
  logic [31:0] fl_wdata;

  flash_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .busy(busy),
    .ram_req(ram_req), .ram_addr(ram_addr), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
    .fl_req(fl_req), .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_ack(fl_ack)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  initial clk = 0;
  always #(P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_st;      // 0 idle, 1 fetch, 2 program, 3 erase
  logic [10:0] m_ram;
  logic [14:0] m_fl, m_fcnt;
  logic [2:0]  m_cmd;
  logic [7:0]  m_cnt;
  int          m_rem;
  logic [31:0] m_buf;

  function automatic logic [31:0] m_read(input logic [9:0] a);
    case (a[9:2])
      8'd0: return {21'd0, m_ram};
      8'd1: return {17'd0, m_fl};
      8'd2: return {16'd0, m_cnt, 5'd0, m_cmd};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit m_busy();
    return m_st != 0;
  endfunction

  initial begin
    m_st = 0; m_ram = 0; m_fl = 0; m_fcnt = 0; m_cmd = 0; m_cnt = 0; m_rem = 0; m_buf = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ram = 0; m_fl = 0; m_fcnt = 0; m_cmd = 0; m_cnt = 0; m_rem = 0; m_buf = 0;
    end else begin
      int nst;
      nst = m_st;
      case (m_st)
        1: if (ram_ack) begin m_buf = ram_rdata; nst = 2; end
        2: if (fl_ack) begin
             m_ram  = m_ram + 11'd1;
             m_fcnt = m_fcnt + 15'd1;
             if (m_rem == 0) nst = 0; else begin m_rem--; nst = 1; end
           end
        3: if (fl_ack) nst = 0;
        default: ;
      endcase
      if (bus_req && bus_we && !m_busy()) begin
        case (bus_addr[9:2])
          8'd0: m_ram = bus_wdata[10:0];
          8'd1: m_fl  = bus_wdata[14:0];
          8'd2: begin m_cmd = bus_wdata[2:0]; m_cnt = bus_wdata[15:8]; end
          8'd3: if (bus_wdata[0]) begin
                  if (m_cmd == 3'd1) nst = 3;
                  else if (m_cmd == 3'd2) begin nst = 1; m_rem = m_cnt; m_fcnt = m_fl; end
                end
          default: ;
        endcase
      end
      m_st = nst;
    end
  end

  // every-cycle comparison, a quarter period after the falling edge
  always @(negedge clk) begin
    #(P/4);
    if (rst_n && !done) begin
      bit exp_ready;
      exp_ready = !(bus_req && bus_we && m_busy());
      chk("R12 busy", {31'd0, busy}, {31'd0, m_busy()});
      chk("R9/R10 bus_ready", {31'd0, bus_ready}, {31'd0, exp_ready});
      chk("R11 bus_err", {31'd0, bus_err},
          {31'd0, bus_req && exp_ready && (bus_addr[9:2] > 8'd3)});
      if (bus_req && !bus_we) chk("R9 bus_rdata", bus_rdata, m_read(bus_addr));
      chk("R7 ram_req", {31'd0, ram_req}, {31'd0, m_st == 1});
      if (m_st == 1) chk("R7 ram_addr", {21'd0, ram_addr}, {21'd0, m_ram});
      chk("R6/R7 fl_req", {31'd0, fl_req}, {31'd0, m_st == 2 || m_st == 3});
      if (m_st == 3) begin
        chk("R6 fl_erase", {31'd0, fl_erase}, 32'd1);
        chk("R6 fl_addr", {17'd0, fl_addr}, {17'd0, m_fl});
      end
      if (m_st == 2) begin
        chk("R7 fl_erase", {31'd0, fl_erase}, 32'd0);
        chk("R7 fl_addr", {17'd0, fl_addr}, {17'd0, m_fcnt});
        chk("R7 fl_wdata", fl_wdata, m_buf);
      end
    end
  end

  // ---------------- RAM / flash responders ----------------
  int rw, fw, prog_acks;
  logic [14:0] last_prog_addr;
  always @(negedge clk) begin
    if (!rst_n) begin
      ram_ack = 0; fl_ack = 0; rw = 0; fw = 0; ram_rdata = 0;
    end else begin
      if (ram_req && !ram_ack) begin
        if (rw == 1) begin ram_ack = 1; ram_rdata = {21'h0F0F0, ram_addr}; rw = 0; end
        else rw++;
      end else ram_ack = 0;
      if (fl_req && !fl_ack) begin
        if (fw == 2) begin
          fl_ack = 1; fw = 0;
          if (!fl_erase) begin prog_acks++; last_prog_addr = fl_addr; end
        end else fw++;
      end else fl_ack = 0;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d, output int waits);
    waits = 0;
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin
      waits++;
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    int w;
    bus_wr(a, d, w);
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1;
    d = bus_rdata; rdy = bus_ready;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (busy) begin @(negedge clk); #1; end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(P * 100000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] d;
    logic        r;
    int          w, base;
    bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    ram_ack = 0; fl_ack = 0; ram_rdata = 0; prog_acks = 0; last_prog_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    #1;
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 ram_req after reset", {31'd0, ram_req}, 32'd0);
    chk("R1 fl_req after reset", {31'd0, fl_req}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      bus_rd(10'(i * 4), d, r);
      chk("R1 register reset value", d, 32'd0);
    end

    // R2 / R3 / R4 field widths
    wr(10'h000, 32'hFFFF_FFFF); bus_rd(10'h000, d, r); chk("R2 ram field", d, 32'h0000_07FF);
    wr(10'h004, 32'hFFFF_FFFF); bus_rd(10'h004, d, r); chk("R3 flash field", d, 32'h0000_7FFF);
    wr(10'h008, 32'hFFFF_FFFF); bus_rd(10'h008, d, r); chk("R4 command fields", d, 32'h0000_FF07);
    wr(10'h00C, 32'hFFFF_FFFE); bus_rd(10'h00C, d, r); chk("R5 exec reads zero", d, 32'd0);
    @(negedge clk); #1; chk("R5 bit0 clear does not start", {31'd0, busy}, 32'd0);

    // R5 no-op command (code 7 held from above) leaves busy low
    wr(10'h00C, 32'd1);
    @(negedge clk); #1; chk("R5 no-op start keeps idle", {31'd0, busy}, 32'd0);

    // R11 unmapped offsets
    wr(10'h010, 32'h1234_5678);
    bus_rd(10'h010, d, r); chk("R11 unmapped read", d, 32'd0);
    bus_rd(10'h3FC, d, r); chk("R11 top of window read", d, 32'd0);
    bus_rd(10'h000, d, r); chk("R11 write ignored", d, 32'h0000_07FF);

    // R6 erase, R9 read while busy, R10 deferred write
    wr(10'h004, 32'h0000_1234);
    wr(10'h008, 32'h0000_0001);
    wr(10'h00C, 32'h0000_0001);
    #1; chk("R12 busy after erase start", {31'd0, busy}, 32'd1);
    bus_rd(10'h004, d, r);
    chk("R9 read ready while busy", {31'd0, r}, 32'd1);
    chk("R9 read value while busy", d, 32'h0000_1234);
    bus_wr(10'h000, 32'h0000_0055, w);
    chk("R10 write stalled while busy", {31'd0, w > 0}, 32'd1);
    bus_rd(10'h000, d, r); chk("R10 deferred write applied", d, 32'h0000_0055);

    // R7 / R8 program of 4 words wrapping the RAM address, polled every cycle
    base = prog_acks;
    wr(10'h000, 32'h0000_07FE);
    wr(10'h004, 32'h0000_0010);
    wr(10'h008, 32'h0000_0302);
    wr(10'h00C, 32'h0000_0001);
    while (busy) bus_rd(10'h000, d, r);
    wait_idle();
    chk("R7 words programmed", 32'(prog_acks - base), 32'd4);
    chk("R7 last flash address", {17'd0, last_prog_addr}, 32'h0000_0013);
    bus_rd(10'h000, d, r); chk("R8 ram address wrapped", d, 32'h0000_0002);
    bus_rd(10'h004, d, r); chk("R3 flash register unchanged", d, 32'h0000_0010);

    // R10 flash write held during program, R7 single word
    base = prog_acks;
    wr(10'h008, 32'h0000_0002);
    wr(10'h00C, 32'h0000_0001);
    bus_wr(10'h004, 32'h0000_2222, w);
    chk("R10 flash write stalled", {31'd0, w > 0}, 32'd1);
    chk("R7 single word program", 32'(prog_acks - base), 32'd1);
    bus_rd(10'h004, d, r); chk("R10 flash write applied", d, 32'h0000_2222);
    bus_rd(10'h000, d, r); chk("R8 single increment", d, 32'h0000_0003);

    // R5 / R10 execute write deferred behind a running program
    base = prog_acks;
    wr(10'h000, 32'h0000_0020);
    wr(10'h004, 32'h0000_0100);
    wr(10'h008, 32'h0000_0102);
    wr(10'h00C, 32'h0000_0001);
    bus_wr(10'h00C, 32'h0000_0001, w);
    chk("R10 exec write stalled", {31'd0, w > 0}, 32'd1);
    wait_idle();
    chk("R5 deferred exec ran second program", 32'(prog_acks - base), 32'd4);
    chk("R7 second program restarts flash address", {17'd0, last_prog_addr}, 32'h0000_0101);
    bus_rd(10'h000, d, r); chk("R8 ram after two programs", d, 32'h0000_0024);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule